// File: doc/BRIEF.md
# Dual Alarm Comparator With Shared Interrupt

This block watches a set of live time-of-day fields and compares them with two programmed alarm sets, once for each one-second tick. Each alarm set has its own per-field match mask. A field whose mask bit is clear is ignored. When every enabled field of an alarm equals the current time on a tick, that alarm's flag is set. The flags stay set until software reads the status register. The status-read logic marks that moment with a one-cycle strobe taken from the eighth serial clock of the read.

The two alarms share one active-low interrupt pin, which can run in one of two modes:

- **Single-event mode:** the pin falls on a match of an armed alarm and stays low until the status read.
- **Pulsed mode:** the pin drops for a fixed number of ticks on every match and keeps doing so until the mode bit or the alarm enables are cleared.

When the frequency output owns the shared pin, the alarm logic leaves the pin high. The flags still record matches.

All control inputs are plain levels or strobes. There is no streaming data path, so no valid/ready handshake is involved.

Top module: `alarm_pair_cmp`

## Requirements
- R1: After reset both flags read 0 and the interrupt pin is high.
- R2: Time field i occupies bits [i*FW +: FW], and alarm k's field i occupies bits [(k*NFIELDS+i)*FW +: FW]. Mask bit k*NFIELDS+i enables field i of alarm k. An alarm matches on a tick when every enabled field equals the time field, and a field with a clear mask bit never blocks a match.
- R3: A match sets that alarm's flag (bit k of the flag output) one cycle after the tick, whatever the state of its enable bit.
- R4: A status-read strobe clears both flags in the following cycle. A match in the same cycle as the strobe leaves its flag set.
- R5: With the mode bit at 0 and the frequency output disabled, a match of an enabled alarm drives the pin low one cycle after the tick. The pin stays low until a status-read strobe, and returns high the cycle after that strobe.
- R6: Either enabled alarm drives the shared pin. After the pin is cleared by a read, a later match of either alarm drives it low again.
- R7: With the mode bit at 1, each match of an enabled alarm holds the pin low from the next cycle for PULSE_TICKS ticks. A new match restarts the pulse. Status reads do not shorten the pulse.
- R8: In pulsed mode, the pin is high one cycle after the mode bit or all alarm enable bits are cleared.
- R9: While the frequency output is enabled, the pin stays high, and matches still set the flags.
- R10: Without a tick, matching fields never set a flag or move the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe once per second |
| now_i | input | NFIELDS*FW | Live time-of-day fields |
| alarm_i | input | NUM_ALARMS*NFIELDS*FW | Alarm field values, alarm k in slice k |
| mask_i | input | NUM_ALARMS*NFIELDS | Per-field match enables |
| alarm_en_i | input | NUM_ALARMS | Per-alarm interrupt enable |
| pulse_mode_i | input | 1 | 0 = held level, 1 = pulse per match |
| fout_en_i | input | 1 | Frequency output owns the pin |
| sr_read_i | input | 1 | Status-read strobe |
| irq_n_o | output | 1 | Shared active-low interrupt |
| flag_o | output | NUM_ALARMS | Per-alarm event flags |

## Verification
The bench builds the block with three fields of eight bits and a pulse width of two ticks. The smaller field count keeps the mask cases short. The two-tick pulse makes it visible that a pulse outlives a tick without a match and that a status read leaves the pulse alone. Two alarms are kept, so the shared-pin retrigger and the read-versus-match collision can both be reached.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  typedef enum logic {
    IRQ_HELD   = 1'b0,
    IRQ_PULSED = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int NFIELDS = 6,
  parameter int FW      = 8
) (
  input  logic                  tick_i,
  input  logic [NFIELDS*FW-1:0] now_i,
  input  logic [NFIELDS*FW-1:0] alarm_i,
  input  logic [NFIELDS-1:0]    mask_i,
  output logic                  hit_o
);
  logic [NFIELDS-1:0] field_ok;

  for (genvar f = 0; f < NFIELDS; f++) begin : g_field
    assign field_ok[f] = !mask_i[f] || (now_i[f*FW +: FW] == alarm_i[f*FW +: FW]);
  end

  assign hit_o = tick_i && (&field_ok);
endmodule

// File: rtl/alarm_flags.sv
module alarm_flags #(
  parameter int NUM_ALARMS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_ALARMS-1:0] hit_i,
  input  logic                  sr_read_i,
  output logic [NUM_ALARMS-1:0] flag_o
);
  for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_o[k] <= 1'b0;
      else if (hit_i[k])    flag_o[k] <= 1'b1;
      else if (sr_read_i)   flag_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_drive.sv
module irq_drive
  import alarm_cmp_pkg::*;
#(
  parameter int NUM_ALARMS  = 2,
  parameter int PULSE_TICKS = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic [NUM_ALARMS-1:0] hit_i,
  input  logic [NUM_ALARMS-1:0] alarm_en_i,
  input  logic                  pulse_mode_i,
  input  logic                  fout_en_i,
  input  logic                  sr_read_i,
  output logic                  irq_n_o
);
  localparam int CW = $clog2(PULSE_TICKS + 1);

  irq_mode_e mode;
  logic      fire;
  logic      held_q;
  logic [CW-1:0] pulse_cnt_q;

  assign mode = irq_mode_e'(pulse_mode_i);
  assign fire = (|(hit_i & alarm_en_i)) && !fout_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          held_q <= 1'b0;
    else if (fire && mode == IRQ_HELD)                   held_q <= 1'b1;
    else if (sr_read_i || mode == IRQ_PULSED || fout_en_i) held_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pulse_cnt_q <= '0;
    else if (mode != IRQ_PULSED || alarm_en_i == '0 || fout_en_i)
      pulse_cnt_q <= '0;
    else if (fire)
      pulse_cnt_q <= CW'(PULSE_TICKS);
    else if (tick_i && pulse_cnt_q != '0)
      pulse_cnt_q <= pulse_cnt_q - CW'(1);
  end

  always_comb begin
    if (fout_en_i)               irq_n_o = 1'b1;
    else if (mode == IRQ_PULSED) irq_n_o = (pulse_cnt_q == '0);
    else                         irq_n_o = !held_q;
  end
endmodule

// File: rtl/alarm_pair_cmp.sv
module alarm_pair_cmp #(
  parameter int NUM_ALARMS  = 2,
  parameter int NFIELDS     = 6,
  parameter int FW          = 8,
  parameter int PULSE_TICKS = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tick_i,
  input  logic [NFIELDS*FW-1:0]            now_i,
  input  logic [NUM_ALARMS*NFIELDS*FW-1:0] alarm_i,
  input  logic [NUM_ALARMS*NFIELDS-1:0]    mask_i,
  input  logic [NUM_ALARMS-1:0]            alarm_en_i,
  input  logic                             pulse_mode_i,
  input  logic                             fout_en_i,
  input  logic                             sr_read_i,
  output logic                             irq_n_o,
  output logic [NUM_ALARMS-1:0]            flag_o
);
  localparam int TW = NFIELDS * FW;

  logic [NUM_ALARMS-1:0] hit;

  for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_alarm
    alarm_match #(.NFIELDS(NFIELDS), .FW(FW)) u_match (
      .tick_i  (tick_i),
      .now_i   (now_i),
      .alarm_i (alarm_i[k*TW +: TW]),
      .mask_i  (mask_i[k*NFIELDS +: NFIELDS]),
      .hit_o   (hit[k])
    );
  end

  alarm_flags #(.NUM_ALARMS(NUM_ALARMS)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_i     (hit),
    .sr_read_i (sr_read_i),
    .flag_o    (flag_o)
  );

  irq_drive #(.NUM_ALARMS(NUM_ALARMS), .PULSE_TICKS(PULSE_TICKS)) u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .hit_i        (hit),
    .alarm_en_i   (alarm_en_i),
    .pulse_mode_i (pulse_mode_i),
    .fout_en_i    (fout_en_i),
    .sr_read_i    (sr_read_i),
    .irq_n_o      (irq_n_o)
  );
endmodule

// File: rtl/alarm_pair_cmp_chk.sv
module alarm_pair_cmp_chk #(
  parameter int NUM_ALARMS = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick_i,
  input logic [NUM_ALARMS-1:0] alarm_en_i,
  input logic                  pulse_mode_i,
  input logic                  fout_en_i,
  input logic                  sr_read_i,
  input logic                  irq_n_o,
  input logic [NUM_ALARMS-1:0] flag_o
);
  AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_o & ~$past(flag_o)) != '0) |-> $past(tick_i)); // R10

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sr_read_i && !tick_i) |-> (flag_o == '0)); // R4

  AST_HELD_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!pulse_mode_i && !fout_en_i && !irq_n_o && !sr_read_i)
      && !pulse_mode_i && !fout_en_i) |-> !irq_n_o); // R5

  AST_PULSE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pulse_mode_i && alarm_en_i == '0) && pulse_mode_i) |-> irq_n_o); // R8

  AST_FOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fout_en_i) && fout_en_i) |-> irq_n_o); // R9
endmodule

bind alarm_pair_cmp alarm_pair_cmp_chk #(.NUM_ALARMS(NUM_ALARMS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_i       (tick_i),
  .alarm_en_i   (alarm_en_i),
  .pulse_mode_i (pulse_mode_i),
  .fout_en_i    (fout_en_i),
  .sr_read_i    (sr_read_i),
  .irq_n_o      (irq_n_o),
  .flag_o       (flag_o)
);

// File: tb/tb_alarm_pair_cmp.sv
module tb_alarm_pair_cmp;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 2;
  localparam int NF = 3;
  localparam int FW = 8;
  localparam int PT = 2;
  localparam int TW = NF * FW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [TW-1:0] now = '0;
  logic [NA*TW-1:0] alarm = '0;
  logic [NA*NF-1:0] mask = '0;
  logic [NA-1:0] en = '0;
  logic          pmode = 1'b0;
  logic          fout = 1'b0;
  logic          rd = 1'b0;
  logic          irq_n;
  logic [NA-1:0] flag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_pair_cmp #(.NUM_ALARMS(NA), .NFIELDS(NF), .FW(FW), .PULSE_TICKS(PT)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .now_i(now), .alarm_i(alarm),
    .mask_i(mask), .alarm_en_i(en), .pulse_mode_i(pmode), .fout_en_i(fout),
    .sr_read_i(rd), .irq_n_o(irq_n), .flag_o(flag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input bit t, input bit r);
    @(negedge clk);
    tick = t; rd = r;
    @(negedge clk);
    tick = 1'b0; rd = 1'b0;
  endtask

  task automatic set_alarm(input int k, input logic [TW-1:0] v, input logic [NF-1:0] m);
    alarm[k*TW +: TW] = v;
    mask[k*NF +: NF] = m;
  endtask

  task automatic clear_all();
    en = '0; pmode = 1'b0; fout = 1'b0;
    pulse(1'b0, 1'b1);
  endtask

  task automatic t_reset();
    check("R1 flags", flag, 0);
    check("R1 irq", irq_n, 1);
  endtask

  task automatic t_mask();
    now = 24'h12_34_56;
    set_alarm(0, 24'h12_99_56, 3'b101);
    set_alarm(1, 24'h00_00_00, 3'b111);
    pulse(1'b1, 1'b0);
    check("R2 masked field ignored", flag, 1);
    check("R3 flag while disabled, pin idle", irq_n, 1);
    pulse(1'b0, 1'b1);
    set_alarm(0, 24'h12_99_56, 3'b111);
    pulse(1'b1, 1'b0);
    check("R2 enabled mismatch blocks", flag, 0);
    clear_all();
  endtask

  task automatic t_notick();
    set_alarm(0, now, 3'b111);
    en = 2'b01;
    for (int i = 0; i < 4; i++) pulse(1'b0, 1'b0);
    check("R10 no flag without tick", flag, 0);
    check("R10 pin idle without tick", irq_n, 1);
    clear_all();
  endtask

  task automatic t_single();
    set_alarm(0, now, 3'b111);
    en = 2'b01;
    pulse(1'b1, 1'b0);
    check("R5 pin low after match", irq_n, 0);
    check("R3 flag0 set", flag, 1);
    for (int i = 0; i < 3; i++) pulse(1'b0, 1'b0);
    check("R5 pin held", irq_n, 0);
    pulse(1'b0, 1'b1);
    check("R5 pin released by read", irq_n, 1);
    check("R4 flags cleared by read", flag, 0);
    clear_all();
  endtask

  task automatic t_shared();
    set_alarm(0, 24'hFF_FF_FF, 3'b111);
    set_alarm(1, now, 3'b010);
    en = 2'b11;
    pulse(1'b1, 1'b0);
    check("R6 alarm1 drives pin", irq_n, 0);
    check("R6 only flag1", flag, 2);
    pulse(1'b0, 1'b1);
    check("R6 cleared", irq_n, 1);
    set_alarm(0, now, 3'b001);
    set_alarm(1, 24'hFF_FF_FF, 3'b111);
    pulse(1'b1, 1'b0);
    check("R6 retrigger by alarm0", irq_n, 0);
    check("R6 only flag0", flag, 1);
    pulse(1'b1, 1'b1);
    check("R4 match beats read", flag, 1);
    clear_all();
    check("R4 cleared afterwards", flag, 0);
  endtask

  task automatic t_pulsed();
    set_alarm(0, now, 3'b111);
    set_alarm(1, 24'hFF_FF_FF, 3'b111);
    en = 2'b01; pmode = 1'b1;
    pulse(1'b1, 1'b0);
    check("R7 pulse starts", irq_n, 0);
    pulse(1'b0, 1'b1);
    check("R7 read leaves pulse", irq_n, 0);
    now = 24'h12_34_57;
    pulse(1'b1, 1'b0);
    check("R7 still low after one tick", irq_n, 0);
    pulse(1'b1, 1'b0);
    check("R7 pulse ends after PT ticks", irq_n, 1);
    now = 24'h12_34_56;
    pulse(1'b1, 1'b0);
    check("R7 repeats on next match", irq_n, 0);
    en = 2'b00;
    pulse(1'b0, 1'b0);
    check("R8 enables cleared stops pulse", irq_n, 1);
    en = 2'b01;
    pulse(1'b1, 1'b0);
    check("R7 rearmed", irq_n, 0);
    pmode = 1'b0;
    @(negedge clk);
    check("R8 mode cleared stops pulse", irq_n, 1);
    clear_all();
  endtask

  task automatic t_fout();
    set_alarm(0, now, 3'b111);
    en = 2'b01; fout = 1'b1;
    pulse(1'b1, 1'b0);
    check("R9 pin left high", irq_n, 1);
    check("R9 flag still set", flag, 1);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_notick();
    t_single();
    t_shared();
    t_pulsed();
    t_fout();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule